// File: doc/BRIEF.md
# Lane Framing Transmitter with Idle Fill and Clock Compensation

This block is the link-layer transmit side of one serial lane that carries two bytes per cycle. It accepts user frames over a ready/valid handshake, in which start-of-frame and end-of-frame flags mark the frame boundaries. For each cycle it emits one 16-bit symbol pair and a 2-bit mask that flags which bytes are control characters. An external 8B/10B encoder takes both.

Each frame is placed between a start-delimiter pair and an end-delimiter pair. Every cycle without user data is filled with an idle pair, and this includes gaps inside a frame. When the final word carries only one byte, its second byte is replaced by a pad character. A free-running scheduler forces a burst of clock-compensation pairs at a fixed interval. During the burst, ready is pulled low, so a frame in progress stalls and then resumes where it left off. While the link is reported down, only idles go out and ready stays low.

The controller has five named states:
- DOWN: the link is not up.
- IDLE: between frames.
- FRAME: data words are being passed through.
- END: the end delimiter is due.
- COMP: a compensation burst is in progress.

Transitions:
- Link loss sends any state to DOWN.
- DOWN moves to IDLE one cycle after the link comes up.
- IDLE moves to FRAME when a start-flagged word is offered, and the start pair is sent at that point.
- FRAME moves to END when the end-flagged word is accepted.
- END moves back to IDLE as it sends the end pair.
- Any state except COMP moves to COMP when the scheduler fires. COMP returns to the saved state after the last compensation pair; if the saved state was DOWN, it returns to IDLE.

Top module: `lane_framer_tx`

## Requirements
- R1: In reset, and in every cycle in which `link_up` is low, `in_ready` is low and the output is the idle pair 16'hBCBC with `out_ctl` 2'b11.
- R2: A word offered with `in_sof` while the block is between frames is not accepted in that cycle. One cycle later the output is the start pair 16'hFB5C with `out_ctl` 2'b11, which comes before that frame's first data pair.
- R3: Accepted frame words appear on `out_sym` unchanged and in order, with `out_ctl` 2'b00. Bits [15:8] carry the first byte on the lane and bits [7:0] the second.
- R4: When the end-flagged word has `in_odd` set, only its bits [15:8] are valid. The output then carries that byte in [15:8], the pad byte 8'h9C in [7:0], and `out_ctl` 2'b01.
- R5: After the last data pair of a frame, the end pair 16'hFDFE with `out_ctl` 2'b11 is sent in a pair of its own.
- R6: Every cycle without a pair to send produces the idle pair 16'hBCBC with `out_ctl` 2'b11, including cycles inside a frame in which the user offers no data.
- R7: While the link stays up, a burst of exactly CC_LEN consecutive pairs 16'hF7F7 with `out_ctl` 2'b11 starts every CC_PERIOD cycles.
- R8: `in_ready` is low in every cycle in which a compensation burst is being issued. A frame that a burst interrupts continues afterwards with no loss or reordering.
- R9: A word offered without `in_sof` while the block is between frames is accepted and discarded, and it never appears on the output.
- R10: If `link_up` drops in the middle of a frame, the frame is abandoned without an end pair. Ready falls at once, and from the next cycle on the output is idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Lane clock |
| rst_n | input | 1 | Active-low synchronous reset |
| link_up | input | 1 | Lane is initialised and may carry frames |
| in_valid | input | 1 | User word is offered |
| in_ready | output | 1 | Block takes the offered word in this cycle |
| in_data | input | 16 | User word; [15:8] goes first on the lane |
| in_sof | input | 1 | Word opens a frame |
| in_eof | input | 1 | Word closes a frame |
| in_odd | input | 1 | With `in_eof`: only [15:8] of the word is valid |
| out_sym | output | 16 | Symbol pair for the encoder |
| out_ctl | output | 2 | Per-byte control flag, bit 1 for [15:8] and bit 0 for [7:0] |

## Verification
The bench builds the block with CC_PERIOD set to 64 and CC_LEN set to 4. With that short period, compensation bursts occur many times within a short run, so the bench can check the spacing between bursts, the length of each burst, and bursts that land in the middle of a frame while the user is stalled. The frame table mixes odd and even byte counts, single-word frames and gapped transfers, so the stream comparison covers padding, idle fill inside frames, and back-to-back frames around the compensation scheduler.

// File: rtl/lft_pkg.sv
package lft_pkg;

    typedef enum logic [2:0] {
        ST_DOWN  = 3'd0,
        ST_IDLE  = 3'd1,
        ST_FRAME = 3'd2,
        ST_END   = 3'd3,
        ST_COMP  = 3'd4
    } lft_state_t;

    localparam logic [15:0] SYM_IDLE = 16'hBCBC;
    localparam logic [15:0] SYM_SOF  = 16'hFB5C;
    localparam logic [15:0] SYM_EOF  = 16'hFDFE;
    localparam logic [15:0] SYM_COMP = 16'hF7F7;
    localparam logic [7:0]  BYTE_PAD = 8'h9C;
    localparam logic [1:0]  CTL_BOTH = 2'b11;
    localparam logic [1:0]  CTL_DATA = 2'b00;
    localparam logic [1:0]  CTL_LOW  = 2'b01;

endpackage

// File: rtl/lft_comp_sched.sv
module lft_comp_sched #(
    parameter int CC_PERIOD = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic link_up,
    output logic cc_due
);
    localparam int CNT_W = (CC_PERIOD > 1) ? $clog2(CC_PERIOD) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(CC_PERIOD - 1);

    logic [CNT_W-1:0] cnt;

    assign cc_due = link_up && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n || !link_up) begin
            cnt <= '0;
        end else if (cc_due) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/lft_word_pack.sv
module lft_word_pack
    import lft_pkg::*;
(
    input  logic [15:0] data,
    input  logic        last,
    input  logic        odd,
    output logic [15:0] sym,
    output logic [1:0]  ctl
);
    always_comb begin
        if (last && odd) begin
            sym = {data[15:8], BYTE_PAD};
            ctl = CTL_LOW;
        end else begin
            sym = data;
            ctl = CTL_DATA;
        end
    end

endmodule

// File: rtl/lane_framer_tx.sv
module lane_framer_tx
    import lft_pkg::*;
#(
    parameter int CC_PERIOD = 5000,
    parameter int CC_LEN    = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        link_up,
    input  logic        in_valid,
    output logic        in_ready,
    input  logic [15:0] in_data,
    input  logic        in_sof,
    input  logic        in_eof,
    input  logic        in_odd,
    output logic [15:0] out_sym,
    output logic [1:0]  out_ctl
);
    localparam int CCN_W = $clog2(CC_LEN + 1);
    localparam logic [CCN_W-1:0] CCN_LAST = CCN_W'(CC_LEN - 1);

    initial begin
        if (CC_LEN < 2 || CC_PERIOD <= CC_LEN + 1) begin
            $error("lane_framer_tx: need CC_LEN >= 2 and CC_PERIOD > CC_LEN + 1");
        end
    end

    lft_state_t       state, nxt_state;
    lft_state_t       saved, nxt_saved;
    logic [CCN_W-1:0] cc_cnt, nxt_cc_cnt;
    logic [15:0]      nxt_sym, pack_sym;
    logic [1:0]       nxt_ctl, pack_ctl;
    logic             cc_due;
    logic             rdy;

    lft_comp_sched #(.CC_PERIOD(CC_PERIOD)) u_sched (
        .clk    (clk),
        .rst_n  (rst_n),
        .link_up(link_up),
        .cc_due (cc_due)
    );

    lft_word_pack u_pack (
        .data(in_data),
        .last(in_eof),
        .odd (in_odd),
        .sym (pack_sym),
        .ctl (pack_ctl)
    );

    always_comb begin
        nxt_state  = state;
        nxt_saved  = saved;
        nxt_cc_cnt = cc_cnt;
        nxt_sym    = SYM_IDLE;
        nxt_ctl    = CTL_BOTH;
        rdy        = 1'b0;
        if (!link_up) begin
            nxt_state  = ST_DOWN;
            nxt_cc_cnt = '0;
        end else if (cc_due && state != ST_COMP) begin
            nxt_state  = ST_COMP;
            nxt_saved  = (state == ST_DOWN) ? ST_IDLE : state;
            nxt_cc_cnt = CCN_W'(1);
            nxt_sym    = SYM_COMP;
        end else begin
            unique case (state)
                ST_DOWN: begin
                    nxt_state = ST_IDLE;
                end
                ST_IDLE: begin
                    if (in_valid && in_sof) begin
                        nxt_sym   = SYM_SOF;
                        nxt_state = ST_FRAME;
                    end else begin
                        rdy = in_valid;
                    end
                end
                ST_FRAME: begin
                    rdy = 1'b1;
                    if (in_valid) begin
                        nxt_sym = pack_sym;
                        nxt_ctl = pack_ctl;
                        if (in_eof) begin
                            nxt_state = ST_END;
                        end
                    end
                end
                ST_END: begin
                    nxt_sym   = SYM_EOF;
                    nxt_state = ST_IDLE;
                end
                ST_COMP: begin
                    nxt_sym = SYM_COMP;
                    if (cc_cnt == CCN_LAST) begin
                        nxt_state  = saved;
                        nxt_cc_cnt = '0;
                    end else begin
                        nxt_cc_cnt = cc_cnt + 1'b1;
                    end
                end
                default: begin
                    nxt_state = ST_DOWN;
                end
            endcase
        end
    end

    assign in_ready = rdy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_DOWN;
            saved  <= ST_IDLE;
            cc_cnt <= '0;
        end else begin
            state  <= nxt_state;
            saved  <= nxt_saved;
            cc_cnt <= nxt_cc_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_sym <= SYM_IDLE;
            out_ctl <= CTL_BOTH;
        end else begin
            out_sym <= nxt_sym;
            out_ctl <= nxt_ctl;
        end
    end

    assert_ready_down_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |-> !in_ready);

    assert_sof_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && !cc_due && state == ST_IDLE && in_valid && in_sof)
        |=> (out_sym == SYM_SOF && out_ctl == CTL_BOTH && state == ST_FRAME));

    assert_pad_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (link_up && !cc_due && state == ST_FRAME && in_valid && in_eof && in_odd)
        |=> (out_ctl == CTL_LOW && out_sym[7:0] == BYTE_PAD));

    assert_end_next_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_END && link_up && !cc_due) |=> (out_sym == SYM_EOF));

    assert_comp_sym_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMP) |-> (out_sym == SYM_COMP && out_ctl == CTL_BOTH));

    assert_comp_stall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMP || cc_due) |-> !in_ready);

    assert_down_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !link_up |=> (out_sym == SYM_IDLE && out_ctl == CTL_BOTH && state == ST_DOWN));

endmodule

// File: tb/lane_framer_tx_tb.sv
module lane_framer_tx_tb_top;
    localparam int P = 64;
    localparam int L = 4;
    localparam int NF = 10;
    // {gap mask [15:8], byte count [7:0]}
    localparam logic [15:0] FRAMES [NF] = '{
        16'h0001, 16'h0202, 16'h0603, 16'h0008, 16'h240D,
        16'h0010, 16'hFF05, 16'h0028, 16'h0A1F, 16'h0002
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        link_up = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_sof = 1'b0;
    logic        in_eof = 1'b0;
    logic        in_odd = 1'b0;
    logic [15:0] in_data = '0;
    logic        in_ready;
    logic [15:0] out_sym;
    logic [1:0]  out_ctl;

    always #4 clk = ~clk;

    lane_framer_tx #(.CC_PERIOD(P), .CC_LEN(L)) dut_i (
        .clk(clk), .rst_n(rst_n), .link_up(link_up),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .in_odd(in_odd),
        .out_sym(out_sym), .out_ctl(out_ctl)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    logic [17:0] exp_q [0:1023];
    logic [17:0] got_q [0:1023];
    int exp_n = 0;
    int got_n = 0;

    function automatic logic [7:0] bval(input int f, input int k);
        return 8'(f * 37 + k * 11 + 5);
    endfunction

    // monitor
    int cyc = 0;
    int run = 0;
    int last_start = -1;
    int runs = 0;
    int cc_in_frame = 0;
    int idle_in_frame = 0;
    bit in_fr = 1'b0;
    bit rec_en = 1'b0;

    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            cyc++;
            if (!link_up) begin
                last_start = -1;
                run = 0;
            end else if (out_ctl == 2'b11 && out_sym == 16'hF7F7) begin
                if (run == 0) begin
                    if (last_start >= 0)
                        chk(cyc - last_start == P, "R7", "burst spacing", cyc - last_start, P);
                    last_start = cyc;
                    if (in_fr) cc_in_frame++;
                end
                run++;
            end else begin
                if (run > 0) begin
                    chk(run == L, "R7", "burst length", run, L);
                    runs++;
                end
                run = 0;
                if (rec_en) begin
                    if (out_ctl == 2'b11 && out_sym == 16'hBCBC) begin
                        if (in_fr) idle_in_frame++;
                    end else begin
                        got_q[got_n] = {out_ctl, out_sym};
                        got_n++;
                        if (out_ctl == 2'b11 && out_sym == 16'hFB5C) in_fr = 1'b1;
                        if (out_ctl == 2'b11 && out_sym == 16'hFDFE) in_fr = 1'b0;
                    end
                end
            end
        end
    end

    task automatic send_word(input logic [15:0] d, input bit sof, input bit eof,
                             input bit odd, output bit took);
        took = 1'b0;
        do begin
            @(negedge clk);
            in_valid = 1'b1; in_data = d; in_sof = sof; in_eof = eof; in_odd = odd;
            #3;
            took = in_ready;
            @(posedge clk);
        end while (!took);
    endtask

    task automatic idle_cycle();
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0; in_odd = 1'b0;
    endtask

    task automatic send_frame(input int f, input int nb, input logic [7:0] gap);
        int nw;
        bit took;
        nw = (nb + 1) / 2;
        exp_q[exp_n] = {2'b11, 16'hFB5C}; exp_n++;
        for (int w = 0; w < nw; w++) begin
            logic [7:0] hi, lo;
            bit last, odd;
            if (gap[w % 8]) idle_cycle();
            hi = bval(f, 2 * w);
            lo = (2 * w + 1 < nb) ? bval(f, 2 * w + 1) : 8'hAA;
            last = (w == nw - 1);
            odd = last && (nb % 2 == 1);
            send_word({hi, lo}, w == 0, last, odd, took);
            if (odd) exp_q[exp_n] = {2'b01, hi, 8'h9C};
            else     exp_q[exp_n] = {2'b00, hi, lo};
            exp_n++;
        end
        exp_q[exp_n] = {2'b11, 16'hFDFE}; exp_n++;
        idle_cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        bit took;
        // reset state
        repeat (4) begin
            @(negedge clk); #1;
            chk(out_sym == 16'hBCBC && out_ctl == 2'b11, "R1", "reset output", {out_ctl, out_sym}, 18'h3BCBC);
            chk(!in_ready, "R1", "reset ready", in_ready, 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        // link down ignores offers
        in_valid = 1'b1; in_sof = 1'b1; in_data = 16'h5555;
        repeat (5) begin
            @(negedge clk); #1;
            chk(!in_ready, "R1", "ready while down", in_ready, 0);
            chk(out_sym == 16'hBCBC && out_ctl == 2'b11, "R1", "idle while down", {out_ctl, out_sym}, 18'h3BCBC);
        end
        idle_cycle();
        link_up = 1'b1;
        rec_en = 1'b1;
        repeat (3) @(negedge clk);

        // table of frames
        for (int f = 0; f < NF; f++) begin
            send_frame(f, int'(FRAMES[f][7:0]), FRAMES[f][15:8]);
            if (f == 2) begin
                send_word(16'h1234, 1'b0, 1'b0, 1'b0, took);
                chk(took, "R9", "stray word accepted", took, 1);
                idle_cycle();
            end
        end
        repeat (3 * P + 10) @(negedge clk);

        // stream comparison
        chk(got_n == exp_n, "R3", "pair count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            string req;
            if (exp_q[i] == {2'b11, 16'hFB5C})      req = "R2";
            else if (exp_q[i] == {2'b11, 16'hFDFE}) req = "R5";
            else if (exp_q[i][17:16] == 2'b01)      req = "R4";
            else                                    req = "R3";
            chk(got_q[i] == exp_q[i], req, "stream pair", got_q[i], exp_q[i]);
        end
        chk(idle_in_frame > 0, "R6", "idles inside frames", idle_in_frame, 1);
        chk(cc_in_frame > 0, "R8", "bursts inside frames", cc_in_frame, 1);
        chk(runs >= 3, "R7", "bursts seen", runs, 3);

        // link loss mid-frame
        rec_en = 1'b0;
        send_word(16'hA1A2, 1'b1, 1'b0, 1'b0, took);
        send_word(16'hA3A4, 1'b0, 1'b0, 1'b0, took);
        @(negedge clk);
        link_up = 1'b0;
        in_valid = 1'b1; in_sof = 1'b0; in_eof = 1'b1; in_data = 16'hA5A6;
        #1;
        chk(!in_ready, "R10", "ready on drop", in_ready, 0);
        repeat (4) begin
            @(negedge clk); #1;
            chk(!in_ready, "R10", "ready after drop", in_ready, 0);
            chk(out_sym == 16'hBCBC && out_ctl == 2'b11, "R10", "idle after drop", {out_ctl, out_sym}, 18'h3BCBC);
        end
        idle_cycle();

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule